// File: doc/BRIEF.md
# Flash Program/Erase Suspend Controller

This block is the slice of a flash command interface that pauses and restarts an embedded program or erase operation. It decodes byte commands from a simple bus. Both suspend and resume are single write cycles. The block remembers whether the paused job was a program or an erase, and it uses that to decide which later commands are allowed. It also chooses what a bus read returns. A countdown counter stands in for the program/erase engine, so the time an operation needs is a fixed number of clock cycles.

A bus write is any clock cycle in which `ce_n` and `we_n` are both low. The command byte is on `din` and the block address is on `addr`. The status byte appears on `dout` when the read source is status. The other read sources are served outside this block and are only announced on `rd_src`.

Top module: `flash_susp_ctrl`

## Requirements
- R1: After reset is released, the controller is ready, has no suspend bit set, has no error and the read source is array (`rd_src`=0). An asserted `rst_n` at any time, including while suspended, aborts the operation in progress.
- R2: While a program runs, the write 8'hB0 pauses the counter and the controller reports ready with the program-suspended bit set. While an erase runs, the same write does this with the erase-suspended bit set instead.
- R3: When nothing is running or suspended, 8'hB0 (suspend) and 8'hD0 (resume) have no effect.
- R4: While a program is suspended, the only accepted writes are resume (8'hD0) and the read commands 8'hFF array, 8'h70 status, 8'h90 signature and 8'h98 query. Program setup (8'h40), erase setup (8'h20), lock setup (8'h60) and protection setup (8'hC0) are ignored.
- R5: While an erase is suspended, program setup 8'h40 and a data cycle to another block run a nested program of PROG_CYC busy cycles. Protection setup 8'hC0 and a data cycle run a protection program of PROG_CYC busy cycles. Either one then returns to erase-suspended.
- R6: Resume (8'hD0) restarts the counter from where it stopped, so the remaining busy cycles equal the full length minus the cycles already run. Reads then return status.
- R7: The status byte is: bit 7 ready, bit 6 erase suspended, bit 4 error, bit 2 program suspended. All other bits are 0, and the two suspend bits are never set together.
- R8: While `ce_n` is high, writes are ignored and a suspended operation keeps its state.
- R9: During an erase suspend, `rd_bad` is high when the read source is array and `addr` equals the block being erased.
- R10: During an erase suspend, a nested program aimed at the block being erased does not run. It sets the error bit and the controller stays erase-suspended.
- R11: A protection program started from ready (8'hC0, then a data cycle) cannot be suspended. A suspend write during it is ignored.
- R12: The read commands set `rd_src`: 8'hFF gives 0 (array), 8'h70 gives 1 (status), 8'h90 gives 2 (signature) and 8'h98 gives 3 (query). Any started, suspended or resumed operation sets the source to status, and it stays status while busy.
- R13: Lock setup 8'h60 followed by 8'h01 (lock) or 8'h2F (lock-down) is accepted from ready and during an erase suspend. It gives a one-cycle `lk_op` pulse of 1 or 2, with `lk_blk` set to the block. 8'hD0 (unlock, `lk_op`=3) is accepted only from ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts any operation |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | BW | Block address |
| din | input | 8 | Command or data byte |
| dout | output | 8 | Status byte when the read source is status, else 0 |
| rd_src | output | 2 | Read source: 0 array, 1 status, 2 signature, 3 query |
| rd_bad | output | 1 | Array read targets the block under suspended erase |
| lk_op | output | 2 | One-cycle lock request: 1 lock, 2 lock-down, 3 unlock |
| lk_blk | output | BW | Block for the lock request |

## Verification
The assertions check properties that must hold on every cycle:
- The two suspend bits are never set together.
- A program suspend is only ever entered from a busy state, and the controller reports ready while suspended.
- Reads point at status whenever the controller is busy.
- `rd_bad` appears only during an erase suspend.
- Lock pulses last a single cycle.
- With chip enable high, a suspended state does not move.

The directed scenarios are needed for behaviour that depends on timing and history:
- how many busy cycles remain after a resume;
- which commands are filtered in each suspend kind;
- rejection of a program aimed at the block being erased;
- the abort caused by reset.

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl #(
  parameter int BW        = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [BW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic [1:0]    rd_src,
  output logic          rd_bad,
  output logic [1:0]    lk_op,
  output logic [BW-1:0] lk_blk
);
  localparam int LEN_MAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW      = $clog2(LEN_MAX + 1);
  localparam logic [CW-1:0] P_LEN = CW'(PROG_CYC);
  localparam logic [CW-1:0] E_LEN = CW'(ERASE_CYC);

  localparam logic [7:0] C_PSET = 8'h40, C_ESET = 8'h20, C_XSET = 8'hC0, C_LSET = 8'h60;
  localparam logic [7:0] C_SUSP = 8'hB0, C_RES  = 8'hD0, C_CLR  = 8'h50;
  localparam logic [7:0] C_RARR = 8'hFF, C_RSTA = 8'h70, C_RSIG = 8'h90, C_RCFI = 8'h98;
  localparam logic [7:0] C_LOCK = 8'h01, C_LDWN = 8'h2F, C_UNLK = 8'hD0;
  localparam logic [1:0] RS_ARR = 2'd0, RS_STA = 2'd1;

  typedef enum logic [3:0] {
    S_RDY, S_PSET, S_ESET, S_XSET, S_LSET, S_RUN, S_PSUS,
    S_ESUS, S_ES_PSET, S_ES_XSET, S_ES_LSET, S_ES_RUN
  } st_t;

  typedef enum logic [1:0] {OP_PROG, OP_ERASE, OP_PROT} op_t;

  st_t st;
  op_t op;
  logic [CW-1:0] cnt, ncnt;
  logic [BW-1:0] eblk;
  logic          err;
  logic [7:0]    sr;

  wire wr   = !ce_n && !we_n;
  wire busy = (st == S_RUN) || (st == S_ES_RUN);
  wire esus = (st == S_ESUS) || (st == S_ES_PSET) || (st == S_ES_XSET) ||
              (st == S_ES_LSET) || (st == S_ES_RUN);
  wire psus = (st == S_PSUS);

  logic       rd_hit;
  logic [1:0] rd_code;
  always_comb begin
    rd_hit  = 1'b1;
    rd_code = RS_ARR;
    case (din)
      C_RARR:  rd_code = 2'd0;
      C_RSTA:  rd_code = 2'd1;
      C_RSIG:  rd_code = 2'd2;
      C_RCFI:  rd_code = 2'd3;
      default: rd_hit  = 1'b0;
    endcase
  end

  assign sr     = {~busy, esus, 1'b0, err, 1'b0, psus, 2'b00};
  assign dout   = (rd_src == RS_STA) ? sr : 8'h00;
  assign rd_bad = esus && (rd_src == RS_ARR) && (addr == eblk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RDY;
      op     <= OP_PROG;
      cnt    <= '0;
      ncnt   <= '0;
      eblk   <= '0;
      err    <= 1'b0;
      rd_src <= RS_ARR;
      lk_op  <= 2'd0;
      lk_blk <= '0;
    end else begin
      lk_op <= 2'd0;
      case (st)
        S_RDY: if (wr) begin
          case (din)
            C_PSET:  st <= S_PSET;
            C_ESET:  st <= S_ESET;
            C_XSET:  st <= S_XSET;
            C_LSET:  st <= S_LSET;
            C_CLR:   err <= 1'b0;
            default: if (rd_hit) rd_src <= rd_code;
          endcase
        end
        S_PSET: if (wr) begin
          st <= S_RUN; op <= OP_PROG; cnt <= P_LEN; rd_src <= RS_STA;
        end
        S_ESET: if (wr) begin
          st <= S_RUN; op <= OP_ERASE; cnt <= E_LEN; eblk <= addr; rd_src <= RS_STA;
        end
        S_XSET: if (wr) begin
          st <= S_RUN; op <= OP_PROT; cnt <= P_LEN; rd_src <= RS_STA;
        end
        S_LSET, S_ES_LSET: if (wr) begin
          st <= (st == S_LSET) ? S_RDY : S_ESUS;
          lk_blk <= addr;
          if (din == C_LOCK) lk_op <= 2'd1;
          else if (din == C_LDWN) lk_op <= 2'd2;
          else if (din == C_UNLK && st == S_LSET) lk_op <= 2'd3;
        end
        S_RUN: begin
          if (wr && din == C_SUSP && op != OP_PROT) begin
            st <= (op == OP_ERASE) ? S_ESUS : S_PSUS;
            rd_src <= RS_STA;
          end else if (cnt <= 1) begin
            st <= S_RDY;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PSUS: if (wr) begin
          if (din == C_RES) begin
            st <= S_RUN; rd_src <= RS_STA;
          end else if (rd_hit) begin
            rd_src <= rd_code;
          end
        end
        S_ESUS: if (wr) begin
          case (din)
            C_RES:   begin st <= S_RUN; rd_src <= RS_STA; end
            C_PSET:  st <= S_ES_PSET;
            C_XSET:  st <= S_ES_XSET;
            C_LSET:  st <= S_ES_LSET;
            default: if (rd_hit) rd_src <= rd_code;
          endcase
        end
        S_ES_PSET: if (wr) begin
          rd_src <= RS_STA;
          if (addr == eblk) begin
            err <= 1'b1; st <= S_ESUS;
          end else begin
            st <= S_ES_RUN; ncnt <= P_LEN;
          end
        end
        S_ES_XSET: if (wr) begin
          st <= S_ES_RUN; ncnt <= P_LEN; rd_src <= RS_STA;
        end
        S_ES_RUN: begin
          if (ncnt <= 1) st <= S_ESUS;
          else ncnt <= ncnt - 1'b1;
        end
        default: st <= S_RDY;
      endcase
    end
  end
endmodule

// File: rtl/flash_susp_ctrl_chk.sv
module flash_susp_ctrl_chk #(
  parameter int BW = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic [7:0] sr,
  input logic [1:0] rd_src,
  input logic       rd_bad,
  input logic [1:0] lk_op
);
  a_r7_susp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr[6] && sr[2]));

  a_r2_psus_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sr[2] |-> sr[7]);

  a_r2_psus_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr[2]) |-> $past(!sr[7]));

  a_r12_busy_reads_status: assert property (@(posedge clk) disable iff (!rst_n)
    !sr[7] |-> rd_src == 2'd1);

  a_r9_bad_only_in_esus: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |-> (sr[6] && rd_src == 2'd0));

  a_r13_lock_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_op != 2'd0) |=> (lk_op == 2'd0));

  a_r8_standby_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && sr[7] && (sr[6] || sr[2])) |=> ($stable(sr) && $stable(rd_src)));
endmodule

bind flash_susp_ctrl flash_susp_ctrl_chk #(.BW(BW)) u_chk (.*);

// File: tb/flash_susp_ctrl_test.sv
module flash_susp_ctrl_test;
  localparam int BW = 4, PC = 8, EC = 40;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1;
  logic [BW-1:0] addr = '0;
  logic [7:0] din = 8'h00, dout;
  logic [1:0] rd_src, lk_op;
  logic rd_bad;
  logic [BW-1:0] lk_blk;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  flash_susp_ctrl #(.BW(BW), .PROG_CYC(PC), .ERASE_CYC(EC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .dout(dout), .rd_src(rd_src), .rd_bad(rd_bad), .lk_op(lk_op), .lk_blk(lk_blk));

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [BW-1:0] a, logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (dout[7] == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd_src", rd_src, 0);
    chk("R1 dout", dout, 0);
    wr(0, 8'h70);
    chk("R1 status", dout, 8'h80);
    chk("R12 status src", rd_src, 1);
  endtask

  task automatic t_idle_suspend();
    wr(0, 8'hB0);
    chk("R3 suspend idle", dout, 8'h80);
    wr(0, 8'hD0);
    chk("R3 resume idle", dout, 8'h80);
    wr(0, 8'h90); chk("R12 sig", rd_src, 2);
    wr(0, 8'h98); chk("R12 cfi", rd_src, 3);
    wr(0, 8'hFF); chk("R12 arr", rd_src, 0);
  endtask

  task automatic t_prog_suspend();
    int n;
    wr(1, 8'h40); wr(1, 8'h55);
    chk("R12 busy status", {rd_src, dout}, {2'd1, 8'h00});
    repeat (2) @(negedge clk);
    wr(0, 8'hB0);
    chk("R2 psus status", dout, 8'h84);
    wr(0, 8'h20); wr(0, 8'h60); wr(0, 8'h01); wr(0, 8'hC0); wr(0, 8'h40);
    chk("R4 filtered", dout, 8'h84);
    chk("R4 no lock", lk_op, 0);
    ce_n = 1'b1; we_n = 1'b0; din = 8'hD0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    chk("R8 standby", dout, 8'h84);
    wr(0, 8'h98);
    chk("R4 read accepted", rd_src, 3);
    wr(0, 8'hD0);
    busy_len(n);
    chk("R6 remaining program", n, PC - 2);
    chk("R6 done status", dout, 8'h80);
  endtask

  task automatic t_erase_suspend();
    int n;
    wr(5, 8'h20); wr(5, 8'hD0);
    repeat (9) @(negedge clk);
    wr(0, 8'hB0);
    chk("R2 esus status", dout, 8'hC0);
    wr(0, 8'hFF);
    addr = 5;
    #1 chk("R9 bad same block", rd_bad, 1);
    addr = 6;
    #1 chk("R9 ok other block", rd_bad, 0);
    wr(6, 8'h60); wr(6, 8'h2F);
    chk("R13 lockdown pulse", {lk_op, lk_blk}, {2'd2, 4'd6});
    @(negedge clk);
    chk("R13 pulse ends", lk_op, 0);
    wr(7, 8'h60); wr(7, 8'hD0);
    chk("R13 unlock refused", lk_op, 0);
    wr(0, 8'h40); wr(5, 8'h12);
    chk("R10 reject same block", dout, 8'hD0);
    wr(2, 8'h40); wr(2, 8'h12);
    chk("R5 nested busy", dout, 8'h50);
    busy_len(n);
    chk("R5 nested length", n, PC);
    chk("R5 back to esus", dout, 8'hD0);
    wr(0, 8'hC0); wr(0, 8'h00);
    busy_len(n);
    chk("R5 nested protection", n, PC);
    wr(0, 8'hD0);
    busy_len(n);
    chk("R6 remaining erase", n, EC - 9);
    chk("R7 done with error", dout, 8'h90);
    wr(0, 8'h50);
    chk("R7 error cleared", dout, 8'h80);
  endtask

  task automatic t_prot();
    int n;
    wr(0, 8'hC0); wr(0, 8'hAA);
    wr(0, 8'hB0);
    chk("R11 not suspended", dout, 8'h00);
    busy_len(n);
    chk("R11 length", n, PC - 1);
    wr(3, 8'h60); wr(3, 8'hD0);
    chk("R13 unlock from ready", {lk_op, lk_blk}, {2'd3, 4'd3});
  endtask

  task automatic t_reset_abort();
    wr(4, 8'h20); wr(4, 8'h00);
    repeat (3) @(negedge clk);
    wr(0, 8'hB0);
    chk("R2 esus before reset", dout, 8'hC0);
    do_reset();
    wr(0, 8'h70);
    chk("R1 aborted", dout, 8'h80);
    wr(0, 8'hD0);
    chk("R3 resume after abort", dout, 8'h80);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_suspend();
    t_prog_suspend();
    t_erase_suspend();
    t_prot();
    t_reset_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule